// File: doc/BRIEF.md
# Remote DMA Host Port

This block gives a byte-wide host bus access to an on-chip packet SRAM through a small paged register file. The host picks a register page with the top two bits of the command register. It loads a 16-bit SRAM start address and a 16-bit byte count on page 0. It then arms a transfer by writing a remote-read or remote-write code into the command register. While the transfer is armed, every access to the single data port moves one byte between the host and SRAM, advances the address and lowers the count. When the count reaches zero, a completion flag is raised in the interrupt status register. Each status bit is cleared by writing a one to it. An interrupt output goes high when any status bit is enabled by the mask.

Page 1 holds configuration bytes used elsewhere on the chip: six station address bytes, a current-page pointer and eight multicast filter bytes. A reset port at the top of the register window gives software a reset. The host reads that port and then writes it, and this stops any transfer, forces the command register back to its idle value and raises the reset status bit. The SRAM size is a power-of-two parameter, and the transfer address wraps from the last byte of the array to byte 0.

Reads are registered: the byte asked for by a read strobe appears on the read data bus in the cycle after the strobe and stays there until the next read.

Top module: `rdma_host_port`

## Requirements
- R1: After reset the command register (offset 0x00, any page) reads 0x21, the interrupt status register (page 0, offset 0x07) reads 0x80, the interrupt mask reads 0x00, `irq` is 0 and `bus_rdata` is 0x00.
- R2: Command bits 7:6 select the register page. On page 1, offsets 0x01–0x06 are six station address bytes, 0x07 is the current-page pointer and 0x08–0x0F are eight multicast filter bytes. All of these are read/write. On page 0 the same offsets reach different registers: 0x07 is the status register and 0x0F is the mask.
- R3: On page 0, offsets 0x08/0x09 write the low/high byte of the transfer address and 0x0A/0x0B write the low/high byte of the byte count. Reading these offsets returns the current address and the remaining count.
- R4: Writing a command whose bits 5:3 are 010 (value 0x10) with a nonzero count arms a remote write. Each write to offset 0x10 then stores the byte at the current address, adds one to the address and subtracts one from the count.
- R5: Writing a command whose bits 5:3 are 001 (value 0x08) with a nonzero count arms a remote read. Each read of offset 0x10 then returns the SRAM byte at the current address on the next cycle, adds one to the address and subtracts one from the count.
- R6: The access that brings the count to zero sets status bit 6 (0x40) and disarms the transfer. After that, data port accesses change neither SRAM, address nor count, and a data port read returns 0x00.
- R7: A remote-read or remote-write command issued while the count is zero arms nothing and sets status bit 6 at once.
- R8: A command with bit 5 set (0x20) ends an armed transfer at once without setting status bit 6. The address and count keep their values, and later data port writes do not reach SRAM.
- R9: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: `irq` is high exactly one cycle after any bit is set in both the status register and the mask (page 0, offset 0x0F).
- R11: The transfer address steps from byte MEM_BYTES-1 to byte 0.
- R12: A read of offset 0x1F followed directly by a write of offset 0x1F disarms any transfer, sets the command register to 0x21 and sets status bit 7 (0x80). A write without that read, or with another access in between, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register window offset (0x00–0x0F registers, 0x10 data port, 0x1F reset port) |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe and held until the next read |
| irq | output | 1 | Registered interrupt request: status AND mask, any bit |

## Verification
The bench goes after the transfer boundaries. It checks the last byte of a transfer, and a design that decremented one step too late would let an extra data-port write overwrite a byte that the bench places just past the window and then reads back. It starts a transfer with a count of zero, where a design that armed anyway would move bytes and never flag completion. It aborts a transfer in the middle, which exposes a design that keeps writing SRAM or raises the completion flag on abort. It makes the address cross the end of the array, where a design without the wrap would read bytes from the wrong place. It also checks that the reset port fires only after a read of that same port directly before, and that writing zeros to the status register does not clear bits.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIN_AW  = 5;
  localparam int XFER_W  = 16;
  localparam int NUM_STA = 6;
  localparam int NUM_MC  = 8;

  localparam logic [WIN_AW-1:0] OFS_DATA  = 5'h10;
  localparam logic [WIN_AW-1:0] OFS_RESET = 5'h1F;

  localparam logic [3:0] REG_CMD    = 4'h0;
  localparam logic [3:0] REG_STAT   = 4'h7;
  localparam logic [3:0] REG_ADR_LO = 4'h8;
  localparam logic [3:0] REG_ADR_HI = 4'h9;
  localparam logic [3:0] REG_CNT_LO = 4'hA;
  localparam logic [3:0] REG_CNT_HI = 4'hB;
  localparam logic [3:0] REG_MASK   = 4'hF;
  localparam logic [3:0] REG_CURPG  = 4'h7;
  localparam logic [3:0] REG_MC0    = 4'h8;

  localparam int STAT_DONE_BIT = 6;
  localparam int STAT_RST_BIT  = 7;

  localparam logic [BYTE_W-1:0] CMD_IDLE  = 8'h21;
  localparam logic [BYTE_W-1:0] STAT_INIT = 8'h80;

  typedef enum logic [1:0] {
    PG_ZERO  = 2'd0,
    PG_ONE   = 2'd1,
    PG_TWO   = 2'd2,
    PG_THREE = 2'd3
  } page_e;

  typedef enum logic [2:0] {
    DMA_NONE  = 3'b000,
    DMA_READ  = 3'b001,
    DMA_WRITE = 3'b010
  } dma_code_e;
endpackage

// File: rtl/rdma_sram.sv
module rdma_sram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  localparam int IW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              ld_adr_lo,
  input  logic              ld_adr_hi,
  input  logic              ld_cnt_lo,
  input  logic              ld_cnt_hi,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              go_abort,
  input  logic              soft_rst,
  output logic [XFER_W-1:0] cur_adr,
  output logic [XFER_W-1:0] cur_cnt,
  output logic              armed,
  output logic              dir_wr,
  output logic              accept,
  output logic              done,
  output logic [IW-1:0]     mem_idx
);
  logic data_rd, data_wr, go_any, last_byte, at_top;
  logic [XFER_W-1:0] adr_step;

  assign data_rd   = bus_rd && (bus_addr == OFS_DATA);
  assign data_wr   = bus_wr && (bus_addr == OFS_DATA);
  assign accept    = armed && (dir_wr ? data_wr : data_rd);
  assign go_any    = go_rd || go_wr;
  assign last_byte = (cur_cnt == XFER_W'(1));
  assign at_top    = (cur_adr[IW-1:0] == IW'(MEM_BYTES - 1));
  assign adr_step  = at_top ? '0 : cur_adr + XFER_W'(1);
  assign mem_idx   = cur_adr[IW-1:0];

  // completion: last accepted byte, or a start with nothing to move
  assign done = !soft_rst && !go_abort &&
                ((go_any && (cur_cnt == '0)) || (accept && last_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      dir_wr  <= 1'b0;
      cur_adr <= '0;
      cur_cnt <= '0;
    end else if (soft_rst || go_abort) begin
      armed <= 1'b0;
    end else if (go_any) begin
      armed  <= (cur_cnt != '0);
      dir_wr <= go_wr;
    end else if (accept) begin
      cur_adr <= adr_step;
      cur_cnt <= cur_cnt - XFER_W'(1);
      armed   <= !last_byte;
    end else begin
      if (ld_adr_lo) cur_adr[7:0]  <= bus_wdata;
      if (ld_adr_hi) cur_adr[15:8] <= bus_wdata;
      if (ld_cnt_lo) cur_cnt[7:0]  <= bus_wdata;
      if (ld_cnt_hi) cur_cnt[15:8] <= bus_wdata;
    end
  end
endmodule

// File: rtl/rdma_regfile.sv
module rdma_regfile
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              done,
  input  logic [XFER_W-1:0] cur_adr,
  input  logic [XFER_W-1:0] cur_cnt,
  output logic              ld_adr_lo,
  output logic              ld_adr_hi,
  output logic              ld_cnt_lo,
  output logic              ld_cnt_hi,
  output logic              go_rd,
  output logic              go_wr,
  output logic              go_abort,
  output logic              soft_rst,
  output logic [BYTE_W-1:0] rd_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] mask_q,
  output page_e             page,
  output logic              irq
);
  logic [BYTE_W-1:0] cmd_q, curpg_q, rd_val, stat_nxt;
  logic [BYTE_W-1:0] sta_q [NUM_STA];
  logic [BYTE_W-1:0] mc_q  [NUM_MC];
  logic [3:0] ofs;
  logic reg_wr, cmd_wr, p0_wr, p1_wr, rst_armed;

  assign ofs    = bus_addr[3:0];
  assign page   = page_e'(cmd_q[7:6]);
  assign reg_wr = bus_wr && !bus_addr[4];
  assign cmd_wr = reg_wr && (ofs == REG_CMD);
  assign p0_wr  = reg_wr && (page == PG_ZERO);
  assign p1_wr  = reg_wr && (page == PG_ONE);

  assign go_abort  = cmd_wr && bus_wdata[5];
  assign go_rd     = cmd_wr && (bus_wdata[5:3] == DMA_READ);
  assign go_wr     = cmd_wr && (bus_wdata[5:3] == DMA_WRITE);
  assign ld_adr_lo = p0_wr && (ofs == REG_ADR_LO);
  assign ld_adr_hi = p0_wr && (ofs == REG_ADR_HI);
  assign ld_cnt_lo = p0_wr && (ofs == REG_CNT_LO);
  assign ld_cnt_hi = p0_wr && (ofs == REG_CNT_HI);
  assign soft_rst  = bus_wr && (bus_addr == OFS_RESET) && rst_armed;

  always_comb begin
    stat_nxt = stat_q;
    if (p0_wr && (ofs == REG_STAT)) stat_nxt = stat_nxt & ~bus_wdata;
    if (done)     stat_nxt[STAT_DONE_BIT] = 1'b1;
    if (soft_rst) stat_nxt[STAT_RST_BIT]  = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (!bus_addr[4]) begin
      if (ofs == REG_CMD) begin
        rd_val = cmd_q;
      end else begin
        unique case (page)
          PG_ZERO: begin
            case (ofs)
              REG_STAT:   rd_val = stat_q;
              REG_ADR_LO: rd_val = cur_adr[7:0];
              REG_ADR_HI: rd_val = cur_adr[15:8];
              REG_CNT_LO: rd_val = cur_cnt[7:0];
              REG_CNT_HI: rd_val = cur_cnt[15:8];
              REG_MASK:   rd_val = mask_q;
              default:    rd_val = '0;
            endcase
          end
          PG_ONE: begin
            if (ofs == REG_CURPG)    rd_val = curpg_q;
            else if (ofs >= REG_MC0) rd_val = mc_q[3'(ofs - REG_MC0)];
            else                     rd_val = sta_q[3'(ofs - 4'd1)];
          end
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_IDLE;
      stat_q    <= STAT_INIT;
      mask_q    <= '0;
      curpg_q   <= '0;
      rd_q      <= '0;
      irq       <= 1'b0;
      rst_armed <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq    <= |(stat_q & mask_q);
      if (bus_rd) rd_q <= rd_val;
      if (bus_rd || bus_wr) rst_armed <= bus_rd && (bus_addr == OFS_RESET);
      if (soft_rst)    cmd_q <= CMD_IDLE;
      else if (cmd_wr) cmd_q <= bus_wdata;
      if (p0_wr && (ofs == REG_MASK))  mask_q  <= bus_wdata;
      if (p1_wr && (ofs == REG_CURPG)) curpg_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_STA; g++) begin : g_sta
    always_ff @(posedge clk) begin
      if (rst) sta_q[g] <= '0;
      else if (p1_wr && (ofs == 4'(g + 1))) sta_q[g] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_MC; g++) begin : g_mc
    always_ff @(posedge clk) begin
      if (rst) mc_q[g] <= '0;
      else if (p1_wr && (ofs == 4'(g + 8))) mc_q[g] <= bus_wdata;
    end
  end
endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
  import rdma_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int IW = $clog2(MEM_BYTES);

  logic ld_adr_lo, ld_adr_hi, ld_cnt_lo, ld_cnt_hi;
  logic go_rd, go_wr, go_abort, soft_rst;
  logic eng_armed, eng_dir_wr, eng_accept, eng_done, sel_mem;
  logic [XFER_W-1:0] eng_adr, eng_cnt;
  logic [IW-1:0]     mem_idx;
  logic [BYTE_W-1:0] reg_rd_q, mem_rd_q, reg_stat, reg_mask;
  page_e reg_page;

  rdma_regfile u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .done(eng_done), .cur_adr(eng_adr), .cur_cnt(eng_cnt),
    .ld_adr_lo(ld_adr_lo), .ld_adr_hi(ld_adr_hi),
    .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
    .go_rd(go_rd), .go_wr(go_wr), .go_abort(go_abort), .soft_rst(soft_rst),
    .rd_q(reg_rd_q), .stat_q(reg_stat), .mask_q(reg_mask),
    .page(reg_page), .irq(irq)
  );

  rdma_engine #(.MEM_BYTES(MEM_BYTES)) u_eng (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .ld_adr_lo(ld_adr_lo), .ld_adr_hi(ld_adr_hi),
    .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
    .go_rd(go_rd), .go_wr(go_wr), .go_abort(go_abort), .soft_rst(soft_rst),
    .cur_adr(eng_adr), .cur_cnt(eng_cnt), .armed(eng_armed), .dir_wr(eng_dir_wr),
    .accept(eng_accept), .done(eng_done), .mem_idx(mem_idx)
  );

  rdma_sram #(.DEPTH(MEM_BYTES), .DW(BYTE_W)) u_mem (
    .clk(clk), .en(eng_accept), .we(eng_dir_wr), .idx(mem_idx),
    .wdata(bus_wdata), .rdata(mem_rd_q)
  );

  // remembers whether the last read was served by SRAM
  always_ff @(posedge clk) begin
    if (rst)         sel_mem <= 1'b0;
    else if (bus_rd) sel_mem <= eng_accept;
  end

  assign bus_rdata = sel_mem ? mem_rd_q : reg_rd_q;
endmodule

// File: rtl/rdma_host_port_chk.sv
module rdma_host_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic        irq,
  input logic [7:0]  stat,
  input logic [7:0]  mask,
  input logic [1:0]  page,
  input logic        armed,
  input logic        dir_wr,
  input logic [15:0] cnt,
  input logic [15:0] adr
);
  logic dport, acc, cmd_go, cmd_abort, stat_wr;

  assign dport     = (bus_addr == 5'h10);
  assign acc       = armed && dport && (dir_wr ? bus_wr : bus_rd);
  assign cmd_go    = bus_wr && (bus_addr == 5'h00) &&
                     ((bus_wdata[5:3] == 3'b001) || (bus_wdata[5:3] == 3'b010));
  assign cmd_abort = bus_wr && (bus_addr == 5'h00) && bus_wdata[5];
  assign stat_wr   = bus_wr && (bus_addr == 5'h07) && (page == 2'd0);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    acc && (cnt != 16'd1) |=> armed && (cnt == $past(cnt) - 16'd1));

  p_last_done_r6: assert property (@(posedge clk) disable iff (rst)
    acc && (cnt == 16'd1) |=> !armed && stat[6]);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !armed && dport && (bus_rd || bus_wr) |=> $stable(cnt) && $stable(adr));

  p_zero_start_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_go && (cnt == 16'd0) |=> !armed && stat[6]);

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> !armed);

  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    stat_wr && bus_wdata[6] |=> !stat[6]);

  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(stat & mask))));
endmodule

bind rdma_host_port rdma_host_port_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq(irq), .stat(reg_stat), .mask(reg_mask),
  .page(reg_page), .armed(eng_armed), .dir_wr(eng_dir_wr),
  .cnt(eng_cnt), .adr(eng_adr)
);

// File: tb/tb_rdma_host_port.sv
`timescale 1ns/1ps
module tb_rdma_host_port;
  localparam int MEM = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  rdma_host_port #(.MEM_BYTES(MEM)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [4:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 5'd1, h);
    v = {h, l};
  endtask

  task automatic xfer(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cmd);
    wr(5'h08, a[7:0]); wr(5'h09, a[15:8]);
    wr(5'h0A, n[7:0]); wr(5'h0B, n[15:8]);
    wr(5'h00, cmd);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "rdata after reset", bus_rdata, 8'h00);
    chk("R1", "irq after reset", irq, 0);
    rd(5'h00, d); chk("R1", "command", d, 8'h21);
    rd(5'h07, d); chk("R1", "status", d, 8'h80);
    rd(5'h0F, d); chk("R1", "mask", d, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(5'h07, 8'h00);
    rd(5'h07, d); chk("R9", "zero write keeps bits", d, 8'h80);
    wr(5'h07, 8'h80);
    rd(5'h07, d); chk("R9", "one write clears", d, 8'h00);
  endtask

  task automatic t_pages();
    logic [7:0] d;
    wr(5'h00, 8'h40);
    for (int i = 1; i <= 6; i++) wr(5'(i), 8'(8'h10 + i));
    wr(5'h07, 8'h46);
    for (int i = 8; i <= 15; i++) wr(5'(i), 8'(8'hA0 + i));
    rd(5'h00, d); chk("R2", "command on page 1", d, 8'h40);
    for (int i = 1; i <= 6; i++) begin
      rd(5'(i), d); chk("R2", "station byte", d, 8'h10 + i);
    end
    rd(5'h07, d); chk("R2", "current page", d, 8'h46);
    for (int i = 8; i <= 15; i++) begin
      rd(5'(i), d); chk("R2", "multicast byte", d, 8'hA0 + i);
    end
    wr(5'h00, 8'h00);
    rd(5'h07, d); chk("R2", "page 0 offset 7 is status", d, 8'h00);
    rd(5'h0F, d); chk("R2", "page 0 offset F is mask", d, 8'h00);
  endtask

  task automatic t_rwrite();
    logic [7:0] d; logic [15:0] v;
    xfer(16'h0127, 16'd1, 8'h10); wr(5'h10, 8'hEE);
    wr(5'h07, 8'hFF);
    xfer(16'h0123, 16'd4, 8'h10);
    wr(5'h10, 8'hC0); wr(5'h10, 8'hC1);
    rd16(5'h0A, v); chk("R4", "count after 2 writes", v, 16'd2);
    rd16(5'h08, v); chk("R3", "address after 2 writes", v, 16'h0125);
    rd(5'h07, d);   chk("R6", "no done mid-transfer", d, 8'h00);
    wr(5'h10, 8'hC2); wr(5'h10, 8'hC3);
    rd(5'h07, d);   chk("R6", "done flag set", d, 8'h40);
    wr(5'h10, 8'h55);
    rd16(5'h08, v); chk("R6", "address frozen after end", v, 16'h0127);
    rd16(5'h0A, v); chk("R6", "count stays zero", v, 16'd0);
    wr(5'h07, 8'h40);
  endtask

  task automatic t_rread();
    logic [7:0] d; logic [15:0] v;
    logic [7:0] exp [5] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hEE};
    xfer(16'h0123, 16'd5, 8'h08);
    for (int i = 0; i < 5; i++) begin
      rd(5'h10, d); chk("R5", "remote read byte", d, exp[i]);
    end
    rd(5'h07, d);   chk("R6", "done after read", d, 8'h40);
    rd(5'h10, d);   chk("R6", "idle data read is zero", d, 8'h00);
    rd16(5'h08, v); chk("R5", "address after read", v, 16'h0128);
    wr(5'h07, 8'h40);
  endtask

  task automatic t_zero();
    logic [7:0] d; logic [15:0] v;
    xfer(16'h0040, 16'd0, 8'h08);
    rd(5'h07, d);   chk("R7", "zero count done at once", d, 8'h40);
    rd(5'h10, d);   chk("R7", "nothing armed", d, 8'h00);
    rd16(5'h08, v); chk("R7", "address unchanged", v, 16'h0040);
    wr(5'h07, 8'h40);
  endtask

  task automatic t_abort();
    logic [7:0] d; logic [15:0] v;
    xfer(16'h0201, 16'd1, 8'h10); wr(5'h10, 8'h11);
    wr(5'h07, 8'h40);
    xfer(16'h0200, 16'd3, 8'h10);
    wr(5'h10, 8'h5A);
    wr(5'h00, 8'h20);
    wr(5'h10, 8'h99);
    rd16(5'h0A, v); chk("R8", "count held", v, 16'd2);
    rd16(5'h08, v); chk("R8", "address held", v, 16'h0201);
    rd(5'h07, d);   chk("R8", "no done on abort", d, 8'h00);
    xfer(16'h0200, 16'd2, 8'h08);
    rd(5'h10, d);   chk("R8", "byte before abort", d, 8'h5A);
    rd(5'h10, d);   chk("R8", "byte after abort untouched", d, 8'h11);
    wr(5'h07, 8'h40);
  endtask

  task automatic t_wrap();
    logic [7:0] d; logic [15:0] v;
    xfer(16'(MEM - 1), 16'd2, 8'h10);
    wr(5'h10, 8'hA1); wr(5'h10, 8'hA2);
    rd16(5'h08, v); chk("R11", "address wrapped", v, 16'h0001);
    xfer(16'(MEM - 1), 16'd2, 8'h08);
    rd(5'h10, d); chk("R11", "last byte", d, 8'hA1);
    rd(5'h10, d); chk("R11", "first byte after wrap", d, 8'hA2);
    xfer(16'h0000, 16'd1, 8'h08);
    rd(5'h10, d); chk("R11", "byte 0 holds wrapped write", d, 8'hA2);
    wr(5'h07, 8'h40);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    xfer(16'h0000, 16'd0, 8'h08);
    repeat (2) @(negedge clk);
    chk("R10", "masked flag no irq", irq, 0);
    wr(5'h0F, 8'h40);
    @(negedge clk);
    chk("R10", "irq on enabled flag", irq, 1);
    rd(5'h0F, d); chk("R10", "mask readback", d, 8'h40);
    wr(5'h07, 8'h40);
    @(negedge clk);
    chk("R10", "irq drops after clear", irq, 0);
    wr(5'h0F, 8'h00);
  endtask

  task automatic t_softrst();
    logic [7:0] d; logic [15:0] v;
    xfer(16'h0300, 16'd4, 8'h10);
    wr(5'h10, 8'h01);
    wr(5'h1F, 8'h00);
    rd(5'h07, d); chk("R12", "bare write no reset", d, 8'h00);
    rd(5'h1F, d); rd(5'h00, d);
    chk("R12", "command before reset", d, 8'h10);
    wr(5'h1F, 8'h00);
    rd(5'h07, d); chk("R12", "broken sequence no reset", d, 8'h00);
    rd(5'h1F, d); wr(5'h1F, 8'h00);
    rd(5'h00, d); chk("R12", "command after reset", d, 8'h21);
    rd(5'h07, d); chk("R12", "reset flag", d, 8'h80);
    wr(5'h10, 8'h02);
    rd16(5'h0A, v); chk("R12", "transfer stopped", v, 16'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_w1c();
    t_pages();
    t_rwrite();
    t_rread();
    t_zero();
    t_abort();
    t_wrap();
    t_irq();
    t_softrst();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule